// File: doc/BRIEF.md
# Power-Capping DVFS Controller for a Core Cluster

This block is a global controller for a small group of cores (two or three in the intended configurations). It keeps the cluster's combined estimated power at or below a programmable budget by picking a supply-voltage level and a clock-frequency level for each core. Every control tick, each core presents a quantized utilization code. The controller multiplies that code by a per-core weight derived from the core's present voltage and frequency levels. It adds the per-core results with saturation and compares the total against the budget word.

The controller works at two rates. Each tick is a fast interval. Every `SLOW_DIV`-th tick, starting with the first tick after reset, is also a slow interval. On a fast interval only frequency moves, and it stays inside the window allowed for the core's voltage. On a slow interval the voltage may also step when frequency has reached the edge of that window.

When the total is over budget, the hungriest core is throttled. When the total is well under budget, cores are raised one at a time in turn. Each interval also records whether it was over budget, and a saturating counter keeps the number of such intervals. Budgets are absolute values in estimate units, so software scales its fraction of maximum power (25 %, 40 %, 50 %, 70 % or 100 %) into the word it writes.

Top module: `dvfs_cap_ctrl`

## Requirements
- R1: After reset every core is at voltage level 0 and frequency level 0, `over_o` is 0, `over_cnt_o` is 0, the turn pointer is at core 0, and the next tick is a slow interval.
- R2: A core at voltage level v always has a frequency level in [F_STEP*v, F_STEP*v+F_SPAN-1] (defaults [2v, 2v+2]), and v never exceeds V_MAX (default 3).
- R3: Levels, flag and counter change only on a clock edge where `tick_i` is 1, and they show the new values from the following cycle. Utilization or budget changes between ticks have no effect on the levels.
- R4: A core's estimate is util*(v+1)^2*(f+1). The total is the sum of the estimates, saturated at 2^PWR_W-1. The interval is over budget when total > budget, so total == budget is not over.
- R5: On an over-budget tick, exactly one core is chosen: the one with the largest estimate, with ties going to the lowest core index. If its frequency is above its window minimum, the frequency drops by one level.
- R6: Ticks are numbered from 0 after reset, and tick k is slow when k mod SLOW_DIV == 0 (SLOW_DIV default 5). Suppose the chosen core of an over-budget slow tick is already at its window minimum with v > 0. Then v drops by one and f is kept. Voltage never changes on a non-slow tick.
- R7: A tick is under budget when it is not over budget and budget − total > GUARD (default 64). On such a tick, the core at the turn pointer raises its frequency by one level if below its window maximum. On a slow tick, a core already at its window maximum with v < V_MAX instead raises v by one and keeps f. The pointer then advances by one, wrapping after the last core.
- R8: A tick that is neither over nor under budget leaves all levels and the turn pointer unchanged. So does an over-budget tick whose chosen core cannot step down.
- R9: `over_o` holds the over-budget result of the most recent tick. `over_cnt_o` increments by one on each over-budget tick and saturates at 2^CNT_W-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle pulse per fast control interval |
| util_i | input | N_CORES*UTIL_W | Utilization code per core, core i at bits [i*UTIL_W +: UTIL_W] |
| budget_i | input | PWR_W | Power budget in estimate units |
| vlvl_o | output | N_CORES*VW | Voltage level per core, core i at [i*VW +: VW] |
| flvl_o | output | N_CORES*FW | Frequency level per core, core i at [i*FW +: FW] |
| over_o | output | 1 | Last tick was over budget |
| over_cnt_o | output | CNT_W | Saturating count of over-budget ticks |

## Verification
Every result is registered on the edge that samples `tick_i`, so levels, `over_o` and `over_cnt_o` are due exactly one cycle after the tick is driven. The bench raises `tick_i` at a falling edge and works out the expected state from the pre-tick levels at that moment. It drops the pulse on the next falling edge and compares there, half a cycle after the updating edge. Between ticks the bench inserts idle cycles that carry fresh utilization values, and it then checks that the levels did not move. Slow-interval numbering is tracked in the bench model from reset, so voltage steps are expected only on the right tick.

// File: rtl/dvfs_pkg.sv
package dvfs_pkg;
  typedef enum logic [1:0] {
    ACT_HOLD = 2'd0,
    ACT_DOWN = 2'd1,
    ACT_UP   = 2'd2
  } dvfs_act_e;
endpackage

// File: rtl/dvfs_lvl_reg.sv
module dvfs_lvl_reg #(
  parameter int V_MAX  = 3,
  parameter int F_STEP = 2,
  parameter int F_SPAN = 3,
  parameter int VW     = 2,
  parameter int FW     = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          slow_i,
  input  logic          dn_i,
  input  logic          up_i,
  output logic [VW-1:0] v_o,
  output logic [FW-1:0] f_o
);
  logic [VW-1:0] v_q;
  logic [FW-1:0] f_q, f_lo, f_hi;

  assign f_lo = FW'(v_q) * FW'(F_STEP);
  assign f_hi = f_lo + FW'(F_SPAN - 1);

  // f is kept across a voltage step: F_SPAN-1 >= F_STEP keeps it in the new window
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v_q <= '0;
      f_q <= '0;
    end else if (tick_i && dn_i) begin
      if (f_q > f_lo)                   f_q <= f_q - 1'b1;
      else if (slow_i && v_q != '0)     v_q <= v_q - 1'b1;
    end else if (tick_i && up_i) begin
      if (f_q < f_hi)                   f_q <= f_q + 1'b1;
      else if (slow_i && v_q != VW'(V_MAX)) v_q <= v_q + 1'b1;
    end
  end

  assign v_o = v_q;
  assign f_o = f_q;

  AST_PAIR_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (f_q >= f_lo) && (f_q <= f_hi) && (v_q <= VW'(V_MAX))); // R2
  AST_V_SLOW_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(tick_i && slow_i) |=> $stable(v_q)); // R6
  AST_LVL_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> ($stable(v_q) && $stable(f_q))); // R3
  AST_F_ONE_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i |=> (f_q == $past(f_q) || f_q == $past(f_q) + 1'b1 || f_q + 1'b1 == $past(f_q))); // R7
endmodule

// File: rtl/dvfs_pwr_est.sv
module dvfs_pwr_est #(
  parameter int UTIL_W = 4,
  parameter int VW     = 2,
  parameter int FW     = 4,
  parameter int TW     = 8,
  parameter int EW     = 12
) (
  input  logic [UTIL_W-1:0] util_i,
  input  logic [VW-1:0]     v_i,
  input  logic [FW-1:0]     f_i,
  output logic [EW-1:0]     est_o
);
  logic [TW-1:0] vp1, fp1, wgt;

  // weight ~ V^2 * F on level indices
  assign vp1   = TW'(v_i) + TW'(1);
  assign fp1   = TW'(f_i) + TW'(1);
  assign wgt   = vp1 * vp1 * fp1;
  assign est_o = EW'(util_i) * EW'(wgt);
endmodule

// File: rtl/dvfs_sel_sum.sv
module dvfs_sel_sum #(
  parameter int N_CORES = 3,
  parameter int EW      = 12,
  parameter int PWR_W   = 16,
  parameter int IW      = 2
) (
  input  logic [N_CORES*EW-1:0] est_i,
  output logic [PWR_W-1:0]      sum_o,
  output logic [IW-1:0]         max_idx_o
);
  localparam int WW = ((EW > PWR_W) ? EW : PWR_W) + $clog2(N_CORES) + 1;
  localparam logic [WW-1:0] SAT = WW'({PWR_W{1'b1}});

  logic [WW-1:0] acc;
  logic [EW-1:0] best;

  always_comb begin
    acc       = '0;
    best      = '0;
    max_idx_o = '0;
    for (int i = 0; i < N_CORES; i++) begin
      acc = acc + WW'(est_i[i*EW +: EW]);
      // strict compare: lowest index keeps a tie
      if (est_i[i*EW +: EW] > best) begin
        best      = est_i[i*EW +: EW];
        max_idx_o = IW'(i);
      end
    end
    sum_o = (acc > SAT) ? {PWR_W{1'b1}} : acc[PWR_W-1:0];
  end
endmodule

// File: rtl/dvfs_cap_ctrl.sv
module dvfs_cap_ctrl
  import dvfs_pkg::*;
#(
  parameter int N_CORES  = 3,
  parameter int UTIL_W   = 4,
  parameter int V_MAX    = 3,
  parameter int F_STEP   = 2,
  parameter int F_SPAN   = 3,
  parameter int SLOW_DIV = 5,
  parameter int PWR_W    = 16,
  parameter int GUARD    = 64,
  parameter int CNT_W    = 8,
  localparam int VW      = $clog2(V_MAX + 1),
  localparam int F_MAX   = V_MAX * F_STEP + F_SPAN - 1,
  localparam int FW      = $clog2(F_MAX + 1)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      tick_i,
  input  logic [N_CORES*UTIL_W-1:0] util_i,
  input  logic [PWR_W-1:0]          budget_i,
  output logic [N_CORES*VW-1:0]     vlvl_o,
  output logic [N_CORES*FW-1:0]     flvl_o,
  output logic                      over_o,
  output logic [CNT_W-1:0]          over_cnt_o
);
  localparam int TW = $clog2((V_MAX + 1) * (V_MAX + 1) * (F_MAX + 1) + 1);
  localparam int EW = UTIL_W + TW;
  localparam int IW = (N_CORES > 1) ? $clog2(N_CORES) : 1;
  localparam int SW = (SLOW_DIV > 1) ? $clog2(SLOW_DIV) : 1;

  logic [N_CORES*EW-1:0] est;
  logic [PWR_W-1:0]      sum, slack;
  logic [IW-1:0]         max_idx, rr_q;
  logic [SW-1:0]         slot_q;
  logic                  slow, over_now, under_now;
  logic                  over_q;
  logic [CNT_W-1:0]      cnt_q;
  dvfs_act_e             act;
  logic [N_CORES-1:0]    dn_vec, up_vec;

  for (genvar g = 0; g < N_CORES; g++) begin : g_core
    dvfs_pwr_est #(
      .UTIL_W(UTIL_W), .VW(VW), .FW(FW), .TW(TW), .EW(EW)
    ) u_est (
      .util_i(util_i[g*UTIL_W +: UTIL_W]),
      .v_i   (vlvl_o[g*VW +: VW]),
      .f_i   (flvl_o[g*FW +: FW]),
      .est_o (est[g*EW +: EW])
    );

    assign dn_vec[g] = (act == ACT_DOWN) && (max_idx == IW'(g));
    assign up_vec[g] = (act == ACT_UP)   && (rr_q == IW'(g));

    dvfs_lvl_reg #(
      .V_MAX(V_MAX), .F_STEP(F_STEP), .F_SPAN(F_SPAN), .VW(VW), .FW(FW)
    ) u_lvl (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .tick_i(tick_i),
      .slow_i(slow),
      .dn_i  (dn_vec[g]),
      .up_i  (up_vec[g]),
      .v_o   (vlvl_o[g*VW +: VW]),
      .f_o   (flvl_o[g*FW +: FW])
    );
  end

  dvfs_sel_sum #(
    .N_CORES(N_CORES), .EW(EW), .PWR_W(PWR_W), .IW(IW)
  ) u_sel (
    .est_i    (est),
    .sum_o    (sum),
    .max_idx_o(max_idx)
  );

  assign slow      = (slot_q == '0);
  assign over_now  = (sum > budget_i);
  assign slack     = budget_i - sum;
  assign under_now = !over_now && (slack > PWR_W'(GUARD));

  always_comb begin
    if (over_now)       act = ACT_DOWN;
    else if (under_now) act = ACT_UP;
    else                act = ACT_HOLD;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slot_q <= '0;
      rr_q   <= '0;
      over_q <= 1'b0;
      cnt_q  <= '0;
    end else if (tick_i) begin
      slot_q <= (slot_q == SW'(SLOW_DIV - 1)) ? '0 : slot_q + 1'b1;
      over_q <= over_now;
      if (act == ACT_UP)
        rr_q <= (rr_q == IW'(N_CORES - 1)) ? '0 : rr_q + 1'b1;
      if (over_now && cnt_q != {CNT_W{1'b1}})
        cnt_q <= cnt_q + 1'b1;
    end
  end

  assign over_o     = over_q;
  assign over_cnt_o = cnt_q;

  // previous-cycle copies for the at-most-one-core check
  logic [N_CORES*VW-1:0] v_prev;
  logic [N_CORES*FW-1:0] f_prev;
  logic [N_CORES-1:0]    moved;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v_prev <= '0;
      f_prev <= '0;
    end else begin
      v_prev <= vlvl_o;
      f_prev <= flvl_o;
    end
  end
  for (genvar g = 0; g < N_CORES; g++) begin : g_mv
    assign moved[g] = (v_prev[g*VW +: VW] != vlvl_o[g*VW +: VW]) ||
                      (f_prev[g*FW +: FW] != flvl_o[g*FW +: FW]);
  end

  AST_ONE_CORE_MOVES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(moved)); // R5
  AST_CNT_MONO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (over_cnt_o >= $past(over_cnt_o))); // R9
  AST_FLAG_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> ($stable(over_o) && $stable(over_cnt_o))); // R3
  AST_CNT_ON_OVER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (over_cnt_o != $past(over_cnt_o)) |-> over_o); // R9
endmodule

// File: tb/sim_dvfs_cap_ctrl.sv
module sim_dvfs_cap_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int N = 3, UW = 4, VW = 2, FW = 4, PW = 16, CW = 8;
  localparam int VMAX = 3, FSTEP = 2, FSPAN = 3, SDIV = 5, GUARD = 64;

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0;
  logic [N*UW-1:0] util = '0;
  logic [PW-1:0]   budget = '0;
  logic [N*VW-1:0] vlvl;
  logic [N*FW-1:0] flvl;
  logic            over;
  logic [CW-1:0]   ocnt;

  always #(CLK_PERIOD/2) clk = ~clk;

  dvfs_cap_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .util_i(util), .budget_i(budget),
    .vlvl_o(vlvl), .flvl_o(flvl), .over_o(over), .over_cnt_o(ocnt)
  );

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  int mv[N], mf[N], uc[N];
  int mrr = 0, mslot = 0, mcnt = 0;
  bit mover = 0;

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int est1(int u, int v, int f);
    return u * (v + 1) * (v + 1) * (f + 1);
  endfunction

  function automatic int msum();
    int s = 0;
    for (int i = 0; i < N; i++) s += est1(uc[i], mv[i], mf[i]);
    return (s > 65535) ? 65535 : s;
  endfunction

  task automatic check_levels(string req);
    for (int i = 0; i < N; i++)
      chk({int'(vlvl[i*VW +: VW]), int'(flvl[i*FW +: FW])} == {mv[i], mf[i]}, req,
          int'(vlvl[i*VW +: VW]) * 16 + int'(flvl[i*FW +: FW]), mv[i] * 16 + mf[i]);
  endtask

  task automatic do_tick(int b, string over_req);
    int s, idx, best, lo, hi;
    bit ov, un, sl;
    string lreq;
    @(negedge clk);
    for (int i = 0; i < N; i++) util[i*UW +: UW] = UW'(uc[i]);
    budget = PW'(b);
    tick = 1'b1;
    s  = msum();
    ov = s > b;
    un = !ov && (b - s > GUARD);
    sl = (mslot == 0);
    lreq = ov ? "R5" : (un ? "R7" : "R8");
    if (ov) begin
      idx = 0; best = -1;
      for (int i = 0; i < N; i++)
        if (est1(uc[i], mv[i], mf[i]) > best) begin best = est1(uc[i], mv[i], mf[i]); idx = i; end
      lo = mv[idx] * FSTEP;
      if (mf[idx] > lo) mf[idx]--;
      else if (sl && mv[idx] > 0) begin mv[idx]--; lreq = "R6"; end
      else lreq = "R8";
      if (mcnt < 255) mcnt++;
    end else if (un) begin
      lo = mv[mrr] * FSTEP; hi = lo + FSPAN - 1;
      if (mf[mrr] < hi) mf[mrr]++;
      else if (sl && mv[mrr] < VMAX) begin mv[mrr]++; lreq = "R6"; end
      mrr = (mrr + 1) % N;
    end
    mover = ov;
    mslot = (mslot + 1) % SDIV;
    @(negedge clk);
    tick = 1'b0;
    chk(over == mover, over_req, int'(over), int'(mover));
    chk(int'(ocnt) == mcnt, "R9", int'(ocnt), mcnt);
    check_levels(lreq);
    for (int i = 0; i < N; i++)
      chk(flvl[i*FW +: FW] >= FW'(vlvl[i*VW +: VW]) * FW'(FSTEP) &&
          flvl[i*FW +: FW] <= FW'(vlvl[i*VW +: VW]) * FW'(FSTEP) + FW'(FSPAN - 1),
          "R2", int'(flvl[i*FW +: FW]), int'(vlvl[i*VW +: VW]) * FSTEP);
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      for (int i = 0; i < N; i++) util[i*UW +: UW] = UW'($urandom_range(15));
      budget = PW'($urandom_range(6480));
    end
    @(negedge clk);
    check_levels("R3");
    chk(int'(ocnt) == mcnt, "R3", int'(ocnt), mcnt);
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    int bl[5] = '{1620, 2592, 3240, 4536, 6480};
    int b, s;
    void'($urandom(32'd1234));
    for (int i = 0; i < N; i++) begin mv[i] = 0; mf[i] = 0; uc[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check_levels("R1");
    chk(over == 1'b0, "R1", int'(over), 0);
    chk(ocnt == '0, "R1", int'(ocnt), 0);

    // R7 round-robin raise, three ticks: each core f 0->1
    for (int i = 0; i < N; i++) uc[i] = 5;
    for (int k = 0; k < 3; k++) do_tick(65535, "R9");
    // R5 tie: equal estimates, core 0 is lowered
    do_tick(0, "R5");
    // R4 boundary: total == budget not over, total-1 over, total+GUARD holds
    s = msum(); do_tick(s, "R4");
    s = msum(); do_tick(s + GUARD, "R4");
    s = msum(); do_tick(s + GUARD + 1, "R4");
    s = msum(); do_tick(s - 1, "R4");
    idle(3);

    // climb to the top (R6 voltage raises on slow ticks)
    for (int i = 0; i < N; i++) uc[i] = 1;
    for (int k = 0; k < 80; k++) do_tick(65535, "R9");
    // drain to the floor (R6 voltage drops on slow ticks)
    for (int i = 0; i < N; i++) uc[i] = 15;
    for (int k = 0; k < 80; k++) do_tick(0, "R9");
    idle(2);

    // constrained random
    b = bl[0];
    for (int k = 0; k < 300; k++) begin
      if (k % 10 == 0) b = bl[$urandom_range(4)];
      for (int i = 0; i < N; i++) uc[i] = $urandom_range(15);
      do_tick(b, "R4");
      if ($urandom_range(3) == 0) idle($urandom_range(3));
    end
    done = 1;
    summary();
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      summary();
    end
  end
endmodule